// File: doc/BRIEF.md
# Enhanced Halt Frequency/Voltage Sequencer

This block decides when a two-thread core may drop into its deep halt operating point, and it walks the core clock ratio and the supply voltage code down and back up in a safe order. It watches one halted flag per logical thread, a configuration enable, and a break-event strobe. Entry is allowed only when the enable is set and every thread is halted. A single halted thread changes nothing, so the other thread runs on at full speed. Only the core clock ratio is ever changed. The external bus clock is not an output of this block and is never touched.

On entry the sequencer records the operating point in force at that moment, which is the nominal ratio and voltage code plus the low targets. It then asks the clock generator for the low ratio. Once that change is acknowledged, it asks the regulator for the low voltage code. Exit runs in the mirror order: the voltage comes back first, then the ratio. Each step holds its request until the matching settle acknowledge arrives. If a break arrives while entry is still in progress, the step under way finishes and the exit starts straight after it. If the break comes during the ratio step, the voltage is never lowered. Snoop requests get their acknowledge in every state, including the low state.

Top module: `ehalt_dvfs_seq`

## Requirements
- R1: A new entry sequence starts only in a cycle where the enable is high, every thread flag is high, and no break is present. `in_ehalt` is high only once both entry steps have been acknowledged and no exit has begun.
- R2: If only some threads are halted, or the enable is low, `busy` stays 0 and the outputs keep following `nom_ratio` and `nom_vid`.
- R3: On entry, `core_ratio_sel` moves to the low ratio first. `vid_code` keeps the saved nominal value until `pll_ack` ends the ratio step, and only then moves to the low code.
- R4: On exit, `vid_code` returns to the saved value first. `core_ratio_sel` stays at the low ratio until `vr_ack` ends the voltage step, and only then returns to the saved ratio.
- R5: The values restored on exit are the ones captured in the cycle entry began, even if `nom_ratio`/`nom_vid` have changed since.
- R6: Each step keeps its request (`ratio_req` for ratio steps, `vid_req` for voltage steps) and its output value until the matching acknowledge is sampled. At most one request is high at a time, and `busy` is high exactly while a request is high.
- R7: `snoop_ack` equals `snoop_req` delayed by one clock, in every state.
- R8: A break seen during either entry step lets that step finish and then starts exit at once. A break during the ratio step goes straight to restoring the ratio, so the voltage code never leaves its saved value.
- R9: After reset the block is idle: no request, `busy` and `in_ehalt` low, and the outputs equal the nominal inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ehalt_en | input | 1 | Allows entry into the deep halt point |
| thread_halted | input | NUM_THREADS | One halted flag per logical thread |
| break_evt | input | 1 | Any decoded break event |
| nom_ratio | input | RATIO_W | Nominal core clock ratio |
| nom_vid | input | VID_W | Nominal voltage code |
| low_ratio | input | RATIO_W | Ratio target for the halt point |
| low_vid | input | VID_W | Voltage code target for the halt point |
| pll_ack | input | 1 | Ratio change has settled |
| vr_ack | input | 1 | Voltage change has settled |
| snoop_req | input | 1 | Incoming snoop |
| core_ratio_sel | output | RATIO_W | Core clock ratio being requested |
| vid_code | output | VID_W | Voltage code toward the regulator |
| ratio_req | output | 1 | Waiting for a ratio change to settle |
| vid_req | output | 1 | Waiting for a voltage change to settle |
| busy | output | 1 | A transition step is in progress |
| in_ehalt | output | 1 | Resting at the low operating point |
| snoop_ack | output | 1 | Snoop serviced |

## Verification
On every cycle, the embedded assertions check four things. A transition may start only from the gated entry condition. A voltage code away from the saved value implies the ratio is already low. While the ratio is back off its low value, the voltage is at its saved value. Requests are one-hot and held until acknowledged, and the snoop acknowledge follows one cycle after the request. Three further behaviours show up only in the bench's scenarios, which compare against a step-queue reference model on every clock. These are the exact restore of the values captured at entry after the nominal inputs have moved, the shortened exit when a break lands during the ratio step, and the fact that a partial halt never starts a sequence.

// File: rtl/ehalt_pkg.sv
package ehalt_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_ENT_R = 3'd1,
    ST_ENT_V = 3'd2,
    ST_LOW   = 3'd3,
    ST_EXT_V = 3'd4,
    ST_EXT_R = 3'd5
  } ehalt_st_e;

  // state groups used by the datapath and the controller
  function automatic logic is_entry(input ehalt_st_e s);
    return (s == ST_ENT_R) || (s == ST_ENT_V);
  endfunction

  function automatic logic ratio_is_low(input ehalt_st_e s);
    return (s == ST_ENT_R) || (s == ST_ENT_V) || (s == ST_LOW) || (s == ST_EXT_V);
  endfunction

  function automatic logic vid_is_low(input ehalt_st_e s);
    return (s == ST_ENT_V) || (s == ST_LOW);
  endfunction

  function automatic logic ratio_step(input ehalt_st_e s);
    return (s == ST_ENT_R) || (s == ST_EXT_R);
  endfunction

  function automatic logic vid_step(input ehalt_st_e s);
    return (s == ST_ENT_V) || (s == ST_EXT_V);
  endfunction

endpackage

// File: rtl/ehalt_entry_gate.sv
module ehalt_entry_gate #(
  parameter int NUM_THREADS = 2
) (
  input  logic                   cfg_en,
  input  logic [NUM_THREADS-1:0] halted,
  output logic                   all_halted,
  output logic                   entry_ok
);
  logic [NUM_THREADS:0] chain;

  assign chain[0] = 1'b1;
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_and
    assign chain[g+1] = chain[g] & halted[g];
  end

  assign all_halted = chain[NUM_THREADS];
  assign entry_ok   = all_halted & cfg_en;
endmodule

// File: rtl/ehalt_step_fsm.sv
module ehalt_step_fsm
  import ehalt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic entry_ok,
  input  logic break_evt,
  input  logic pll_ack,
  input  logic vr_ack,
  output logic capture,
  output logic run_ph,
  output logic ratio_low_ph,
  output logic vid_low_ph,
  output logic ratio_req,
  output logic vid_req,
  output logic busy,
  output logic in_low
);
  ehalt_st_e st_q, st_d;
  logic      pend_q;
  logic      go_exit;

  assign go_exit = pend_q | break_evt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:   if (entry_ok && !break_evt) st_d = ST_ENT_R;
      ST_ENT_R: if (pll_ack) st_d = go_exit ? ST_EXT_R : ST_ENT_V;
      ST_ENT_V: if (vr_ack)  st_d = go_exit ? ST_EXT_V : ST_LOW;
      ST_LOW:   if (break_evt) st_d = ST_EXT_V;
      ST_EXT_V: if (vr_ack)  st_d = ST_EXT_R;
      ST_EXT_R: if (pll_ack) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= is_entry(st_d) ? go_exit : 1'b0;
    end
  end

  assign capture      = (st_q == ST_RUN) && (st_d == ST_ENT_R);
  assign run_ph       = (st_q == ST_RUN);
  assign ratio_low_ph = ratio_is_low(st_q);
  assign vid_low_ph   = vid_is_low(st_q);
  assign ratio_req    = ratio_step(st_q);
  assign vid_req      = vid_step(st_q);
  assign busy         = ratio_req | vid_req;
  assign in_low       = (st_q == ST_LOW);

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ratio_req, vid_req})); // R6
  AST_HOLD_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_req && !pll_ack) |=> ratio_req); // R6
  AST_HOLD_VID: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && !vr_ack) |=> vid_req); // R6
endmodule

// File: rtl/ehalt_opp_hold.sv
module ehalt_opp_hold #(
  parameter int RATIO_W = 6,
  parameter int VID_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               run_ph,
  input  logic               ratio_low_ph,
  input  logic               vid_low_ph,
  input  logic [RATIO_W-1:0] nom_ratio,
  input  logic [VID_W-1:0]   nom_vid,
  input  logic [RATIO_W-1:0] low_ratio,
  input  logic [VID_W-1:0]   low_vid,
  output logic [RATIO_W-1:0] sav_ratio,
  output logic [VID_W-1:0]   sav_vid,
  output logic [RATIO_W-1:0] tgt_ratio,
  output logic [VID_W-1:0]   tgt_vid,
  output logic [RATIO_W-1:0] ratio_out,
  output logic [VID_W-1:0]   vid_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sav_ratio <= '0;
      sav_vid   <= '0;
      tgt_ratio <= '0;
      tgt_vid   <= '0;
    end else if (capture) begin
      sav_ratio <= nom_ratio;
      sav_vid   <= nom_vid;
      tgt_ratio <= low_ratio;
      tgt_vid   <= low_vid;
    end
  end

  always_comb begin
    if (run_ph)            ratio_out = nom_ratio;
    else if (ratio_low_ph) ratio_out = tgt_ratio;
    else                   ratio_out = sav_ratio;
    if (run_ph)            vid_out = nom_vid;
    else if (vid_low_ph)   vid_out = tgt_vid;
    else                   vid_out = sav_vid;
  end
endmodule

// File: rtl/ehalt_snoop_path.sv
module ehalt_snoop_path (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= req;
  end

  AST_SNOOP_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack); // R7
endmodule

// File: rtl/ehalt_dvfs_seq.sv
module ehalt_dvfs_seq #(
  parameter int NUM_THREADS = 2,
  parameter int RATIO_W     = 6,
  parameter int VID_W       = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_ehalt_en,
  input  logic [NUM_THREADS-1:0] thread_halted,
  input  logic                   break_evt,
  input  logic [RATIO_W-1:0]     nom_ratio,
  input  logic [VID_W-1:0]       nom_vid,
  input  logic [RATIO_W-1:0]     low_ratio,
  input  logic [VID_W-1:0]       low_vid,
  input  logic                   pll_ack,
  input  logic                   vr_ack,
  input  logic                   snoop_req,
  output logic [RATIO_W-1:0]     core_ratio_sel,
  output logic [VID_W-1:0]       vid_code,
  output logic                   ratio_req,
  output logic                   vid_req,
  output logic                   busy,
  output logic                   in_ehalt,
  output logic                   snoop_ack
);
  logic               all_halted, entry_ok;
  logic               capture, run_ph, ratio_low_ph, vid_low_ph;
  logic [RATIO_W-1:0] sav_ratio, tgt_ratio;
  logic [VID_W-1:0]   sav_vid, tgt_vid;

  ehalt_entry_gate #(.NUM_THREADS(NUM_THREADS)) u_gate (
    .cfg_en(cfg_ehalt_en), .halted(thread_halted),
    .all_halted(all_halted), .entry_ok(entry_ok)
  );

  ehalt_step_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .entry_ok(entry_ok), .break_evt(break_evt),
    .pll_ack(pll_ack), .vr_ack(vr_ack), .capture(capture), .run_ph(run_ph),
    .ratio_low_ph(ratio_low_ph), .vid_low_ph(vid_low_ph),
    .ratio_req(ratio_req), .vid_req(vid_req), .busy(busy), .in_low(in_ehalt)
  );

  ehalt_opp_hold #(.RATIO_W(RATIO_W), .VID_W(VID_W)) u_opp (
    .clk(clk), .rst_n(rst_n), .capture(capture), .run_ph(run_ph),
    .ratio_low_ph(ratio_low_ph), .vid_low_ph(vid_low_ph),
    .nom_ratio(nom_ratio), .nom_vid(nom_vid),
    .low_ratio(low_ratio), .low_vid(low_vid),
    .sav_ratio(sav_ratio), .sav_vid(sav_vid),
    .tgt_ratio(tgt_ratio), .tgt_vid(tgt_vid),
    .ratio_out(core_ratio_sel), .vid_out(vid_code)
  );

  ehalt_snoop_path u_snoop (
    .clk(clk), .rst_n(rst_n), .req(snoop_req), .ack(snoop_ack)
  );

  AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy) && !$past(in_ehalt)) |-> $past(entry_ok)); // R1
  AST_PARTIAL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_ehalt && !all_halted) |=> !in_ehalt); // R2
  AST_RATIO_BEFORE_VID: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy || in_ehalt) && vid_code != sav_vid) |-> core_ratio_sel == tgt_ratio); // R3
  AST_VID_BEFORE_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && core_ratio_sel != tgt_ratio) |-> vid_code == sav_vid); // R4
endmodule

// File: tb/ehalt_dvfs_seq_tb.sv
module ehalt_dvfs_seq_tb;
  localparam int NT = 2, RW = 6, VW = 6;

  logic          clk = 0, rst_n = 0;
  logic          cfg_ehalt_en = 0, break_evt = 0, pll_ack = 0, vr_ack = 0, snoop_req = 0;
  logic [NT-1:0] thread_halted = '0;
  logic [RW-1:0] nom_ratio = 6'd20, low_ratio = 6'd8;
  logic [VW-1:0] nom_vid = 6'd40, low_vid = 6'd25;
  logic [RW-1:0] core_ratio_sel;
  logic [VW-1:0] vid_code;
  logic          ratio_req, vid_req, busy, in_ehalt, snoop_ack;

  int checks = 0, fails = 0;
  int pll_dly = 2, vr_dly = 3, pll_cnt = 0, vr_cnt = 0;

  always #2 clk = ~clk; // 250 MHz

  ehalt_dvfs_seq #(.NUM_THREADS(NT), .RATIO_W(RW), .VID_W(VW)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: a queue of pending steps 1=ratio down 2=vid down 3=vid up 4=ratio up
  int q[$];
  bit m_low, m_pend, r_low, v_low, m_snp;
  int sr, sv, lr, lv;

  task automatic model_step();
    if (!rst_n) begin
      q.delete(); m_low = 0; m_pend = 0; r_low = 0; v_low = 0; m_snp = 0;
      return;
    end
    if (q.size() == 0 && !m_low) begin
      if (cfg_ehalt_en && (&thread_halted) && !break_evt) begin
        sr = nom_ratio; sv = nom_vid; lr = low_ratio; lv = low_vid;
        q.push_back(1); q.push_back(2);
      end
    end else if (q.size() == 0) begin
      if (break_evt) begin m_low = 0; q.push_back(3); q.push_back(4); end
    end else begin
      int h;
      bit a;
      h = q[0];
      a = (h == 1 || h == 4) ? pll_ack : vr_ack;
      if (h <= 2 && break_evt) m_pend = 1;
      if (a) begin
        void'(q.pop_front());
        if (h <= 2 && m_pend) begin
          q.delete(); m_pend = 0;
          if (v_low) q.push_back(3);
          q.push_back(4);
        end else if (h == 2) m_low = 1;
      end
    end
    if (q.size() > 0)
      case (q[0])
        1: r_low = 1;
        2: v_low = 1;
        3: v_low = 0;
        default: r_low = 0;
      endcase
    m_snp = snoop_req;
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    model_step();
    if (rst_n) begin
      int er, ev, h;
      bit idle;
      idle = (q.size() == 0 && !m_low);
      h = (q.size() > 0) ? q[0] : 0;
      er = idle ? int'(nom_ratio) : (r_low ? lr : sr);
      ev = idle ? int'(nom_vid)   : (v_low ? lv : sv);
      chk(int'(core_ratio_sel) == er, "R3 core_ratio_sel", core_ratio_sel, er);
      chk(int'(vid_code) == ev, "R4 vid_code", vid_code, ev);
      chk(ratio_req == (h == 1 || h == 4), "R6 ratio_req", ratio_req, (h == 1 || h == 4));
      chk(vid_req == (h == 2 || h == 3), "R6 vid_req", vid_req, (h == 2 || h == 3));
      chk(busy == (q.size() > 0), "R6 busy", busy, (q.size() > 0));
      chk(in_ehalt == (m_low && q.size() == 0), "R1 in_ehalt", in_ehalt, m_low);
      chk(snoop_ack == m_snp, "R7 snoop_ack", snoop_ack, m_snp);
    end
  end

  // settle-acknowledge responders
  always @(negedge clk) begin
    #1;
    if (pll_ack) begin pll_ack = 0; pll_cnt = 0; end
    else if (ratio_req) begin pll_cnt++; if (pll_cnt > pll_dly) pll_ack = 1; end
    else pll_cnt = 0;
    if (vr_ack) begin vr_ack = 0; vr_cnt = 0; end
    else if (vid_req) begin vr_cnt++; if (vr_cnt > vr_dly) vr_ack = 1; end
    else vr_cnt = 0;
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse_break();
    break_evt = 1; thread_halted = '0; tick(1); break_evt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    bit seen;
    tick(3); rst_n = 1; tick(1);
    chk(core_ratio_sel == 20 && vid_code == 40, "R9 outputs after reset", core_ratio_sel, 20);
    chk(!busy && !in_ehalt && !ratio_req && !vid_req, "R9 idle after reset", busy, 0);

    cfg_ehalt_en = 1; thread_halted = 2'b01; tick(12);
    chk(!busy && !in_ehalt, "R2 one thread halted", busy, 0);
    chk(core_ratio_sel == 20, "R2 ratio unchanged", core_ratio_sel, 20);
    cfg_ehalt_en = 0; thread_halted = 2'b11; tick(12);
    chk(!busy && vid_code == 40, "R2 enable clear", vid_code, 40);

    // full entry and exit with nominal moved while low
    cfg_ehalt_en = 1;
    for (int i = 0; i < 100 && !in_ehalt; i++) tick(1);
    chk(in_ehalt == 1, "R1 reached low point", in_ehalt, 1);
    nom_ratio = 30; nom_vid = 50; tick(3);
    chk(core_ratio_sel == 8 && vid_code == 25, "R3 low point values", vid_code, 25);
    pulse_break();
    for (int i = 0; i < 100 && !vid_req; i++) tick(1);
    chk(vid_code == 40, "R5 voltage restored to captured", vid_code, 40);
    chk(core_ratio_sel == 8, "R4 ratio still low while voltage restores", core_ratio_sel, 8);
    for (int i = 0; i < 100 && !ratio_req; i++) tick(1);
    chk(core_ratio_sel == 20, "R5 ratio restored to captured", core_ratio_sel, 20);
    for (int i = 0; i < 100 && busy; i++) tick(1);
    chk(core_ratio_sel == 30, "R2 follows new nominal", core_ratio_sel, 30);

    // break during the ratio step
    nom_ratio = 20; nom_vid = 40; pll_dly = 4; thread_halted = 2'b11;
    for (int i = 0; i < 100 && !ratio_req; i++) tick(1);
    tick(1); pulse_break();
    cnt = 0; seen = 0;
    for (int i = 0; i < 100 && busy; i++) begin
      if (vid_code == low_vid) cnt++;
      if (in_ehalt) seen = 1;
      tick(1);
    end
    chk(cnt == 0, "R8 voltage untouched on early break", cnt, 0);
    chk(!seen, "R8 no low point on early break", seen, 0);

    // break during the voltage step
    vr_dly = 4; thread_halted = 2'b11;
    for (int i = 0; i < 100 && !vid_req; i++) tick(1);
    pulse_break();
    seen = 0;
    for (int i = 0; i < 100 && busy; i++) begin
      if (in_ehalt) seen = 1;
      tick(1);
    end
    chk(!seen && core_ratio_sel == 20 && vid_code == 40, "R8 exit after voltage step", core_ratio_sel, 20);

    // random traffic, checked by the model every cycle
    for (int i = 0; i < 3000; i++) begin
      cfg_ehalt_en  = ($urandom % 8) != 0;
      thread_halted = ($urandom % 3 == 0) ? 2'b11 : NT'($urandom);
      break_evt     = ($urandom % 12) == 0;
      snoop_req     = $urandom;
      if ($urandom % 16 == 0) begin nom_ratio = RW'($urandom); nom_vid = VW'($urandom); end
      pll_dly = $urandom % 5; vr_dly = $urandom % 5;
      tick(1);
    end
    break_evt = 0; snoop_req = 0;
    tick(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule